// File: doc/BRIEF.md
# MSI Event Queue Record Writer

This block sits behind the interrupt decode stage of a PCIe root port. Each decoded interrupt event is turned into a fixed 64-byte record and appended to a circular queue in main memory. The event can be an MSI with a 32-bit or 64-bit address, an MSI-X, a PCIe message or an INTx assertion. The record is written as eight 64-bit words through a simple valid/ready word-write master. What goes into each word depends on the event kind.

Software sets the queue base address, the enable bit, the INTx system interrupt number and the head pointer through plain configuration inputs. The block owns the tail pointer. It raises a level interrupt while the queue holds unconsumed records. If an event arrives with no free slot, the block drops it and latches an error state. Further events are discarded until software clears the error.

Top module: `msi_eq_writer`

## Requirements
- R1: After reset, `mem_valid_o`, `irq_o` and `q_error_o` are 0, `tail_o` is 0 and `ev_ready_o` is 1.
- R2: An accepted event produces exactly eight word writes. Word k of slot t goes to address `cfg_base_i + t*64 + k*8`, for k = 0 to 7 in order. `tail_o` advances by one, modulo DEPTH, only after the eighth word is accepted.
- R3: `ev_kind_i` uses this encoding: 0 is MSI32, 1 is MSI64, 2 is MSI-X, 3 is message and 4 is INTx. Word 0 holds the record type code in bits 7:0, and its other bits are zero. The codes are message=1, MSI32=2, MSI64=3 and INTx=8. An MSI-X event uses code 3 when address bits 63:32 are nonzero, and code 2 otherwise.
- R4: Word 1 holds `cfg_sysino_i` for INTx events and is zero for all other kinds. Words 2 and 7 are zero. Word 3 holds a nonzero timestamp taken from a free-running counter when the event is accepted, so it strictly increases from one record to the next.
- R5: Word 4 holds the requester ID in bits 15:0, or zero for INTx. Word 5 holds the MSI address: only the low 32 bits for MSI32, the full 64 bits for MSI64 and MSI-X, and zero for message and INTx events.
- R6: Word 6 depends on the kind. For MSI32 and MSI64 it holds data bits 15:0. For MSI-X it holds data bits 31:0. For a message, the target is in bits 39:32, the routing code in bits 18:16 and the message code in bits 7:0. For INTx, the pin is in bits 1:0, with A=0, B=1, C=2 and D=3. All other bits are zero.
- R7: The block discards an event without writing anything and leaves `tail_o` unchanged in two cases: when `cfg_enable_i` is 0, and when `ev_kind_i` is 5, 6 or 7.
- R8: While `mem_valid_o` is 1 and `mem_ready_i` is 0, the address and data outputs hold steady.
- R9: The queue is full when tail+1 equals `head_i`. An event that arrives while the queue is full is dropped, `q_error_o` is set and the tail stays put. While `q_error_o` is 1, every event is discarded. A pulse on `err_clr_i` returns the queue to idle.
- R10: `irq_o` is 1 exactly when `cfg_enable_i` is 1 and `head_i` differs from `tail_o`.
- R11: `ev_ready_o` is 0 while a record is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Event present |
| ev_ready_o | output | 1 | Block can take an event |
| ev_kind_i | input | 3 | Event kind code |
| ev_rid_i | input | 16 | Requester bus.device.function |
| ev_addr_i | input | 64 | MSI address |
| ev_data_i | input | 32 | MSI / MSI-X data |
| ev_msg_tgt_i | input | 8 | Message target |
| ev_msg_route_i | input | 3 | Message routing code |
| ev_msg_code_i | input | 8 | Message code |
| ev_intx_i | input | 2 | INTx pin |
| cfg_enable_i | input | 1 | Queue enable |
| cfg_base_i | input | ADDR_W | Queue base address, aligned to DEPTH*64 |
| cfg_sysino_i | input | 64 | System interrupt number for INTx records |
| head_i | input | IDX_W | Software head pointer |
| err_clr_i | input | 1 | Clear the error state |
| mem_valid_o | output | 1 | Word write request |
| mem_ready_i | input | 1 | Word write accepted |
| mem_addr_o | output | ADDR_W | Word byte address |
| mem_data_o | output | 64 | Word data |
| tail_o | output | IDX_W | Tail pointer |
| irq_o | output | 1 | Queue non-empty interrupt |
| q_error_o | output | 1 | Queue in error state |

## Verification
The overflow path is the hardest state to reach from the ports. To reach it, software must hold the head still while fifteen complete records, each of eight stalled word writes, are appended. Only then does the sixteenth event hit a full queue. The bench freezes `head_i` at the current tail and pushes fifteen events against a randomly stalling memory port. It then checks that the next two events are dropped and that the error state latches. After that it drains the queue, clears the error and confirms that writing resumes.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;
  typedef enum logic [2:0] {
    EV_MSI32 = 3'd0,
    EV_MSI64 = 3'd1,
    EV_MSIX  = 3'd2,
    EV_MSG   = 3'd3,
    EV_INTX  = 3'd4
  } ev_kind_e;

  localparam logic [7:0] REC_MSG   = 8'd1;
  localparam logic [7:0] REC_MSI32 = 8'd2;
  localparam logic [7:0] REC_MSI64 = 8'd3;
  localparam logic [7:0] REC_INTX  = 8'd8;

  localparam int REC_WORDS = 8;
  localparam int WORD_W    = 64;

  typedef logic [REC_WORDS-1:0][WORD_W-1:0] rec_t;

  typedef enum logic {WR_IDLE = 1'b0, WR_BUSY = 1'b1} wr_state_e;
endpackage

// File: rtl/msi_eq_fmt.sv
module msi_eq_fmt
  import msi_eq_pkg::*;
#(
  parameter int TS_W  = 64,
  parameter bit TS_EN = 1'b1
) (
  input  logic [2:0]      kind_i,
  input  logic [15:0]     rid_i,
  input  logic [63:0]     addr_i,
  input  logic [31:0]     data_i,
  input  logic [7:0]      tgt_i,
  input  logic [2:0]      route_i,
  input  logic [7:0]      code_i,
  input  logic [1:0]      intx_i,
  input  logic [63:0]     sysino_i,
  input  logic [TS_W-1:0] ts_i,
  output logic            legal_o,
  output rec_t            words_o
);
  logic [63:0] ts_word;
  logic [7:0]  rtype;

  generate
    if (TS_EN) begin : g_ts
      assign ts_word = 64'(ts_i);
    end else begin : g_no_ts
      assign ts_word = '0;
    end
  endgenerate

  always_comb begin
    words_o = '0;
    legal_o = 1'b1;
    rtype   = 8'h00;
    case (kind_i)
      EV_MSI32: begin
        rtype      = REC_MSI32;
        words_o[4] = {48'h0, rid_i};
        words_o[5] = {32'h0, addr_i[31:0]};
        words_o[6] = {48'h0, data_i[15:0]};
      end
      EV_MSI64: begin
        rtype      = REC_MSI64;
        words_o[4] = {48'h0, rid_i};
        words_o[5] = addr_i;
        words_o[6] = {48'h0, data_i[15:0]};
      end
      EV_MSIX: begin
        rtype      = (|addr_i[63:32]) ? REC_MSI64 : REC_MSI32;
        words_o[4] = {48'h0, rid_i};
        words_o[5] = addr_i;
        words_o[6] = {32'h0, data_i};
      end
      EV_MSG: begin
        rtype      = REC_MSG;
        words_o[4] = {48'h0, rid_i};
        words_o[6] = {24'h0, tgt_i, 13'h0, route_i, 8'h0, code_i};
      end
      EV_INTX: begin
        rtype      = REC_INTX;
        words_o[1] = sysino_i;
        words_o[6] = {62'h0, intx_i};
      end
      default: legal_o = 1'b0;
    endcase
    words_o[0] = {56'h0, rtype};
    words_o[3] = ts_word;
  end
endmodule

// File: rtl/msi_eq_ptr.sv
module msi_eq_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic             advance_i,
  input  logic             overflow_i,
  input  logic             err_clr_i,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic             error_o,
  output logic             irq_o
);
  logic [IDX_W-1:0] tail_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (advance_i) tail_q <= tail_q + IDX_W'(1);
      if (overflow_i)     err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign tail_o  = tail_q;
  assign error_o = err_q;
  assign full_o  = (tail_q + IDX_W'(1)) == head_i;
  assign irq_o   = enable_i && (tail_q != head_i);
endmodule

// File: rtl/msi_eq_wr.sv
module msi_eq_wr
  import msi_eq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  rec_t              words_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  tail_i,
  output logic              idle_o,
  output logic              done_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_data_o
);
  localparam int WI_W = $clog2(REC_WORDS);

  wr_state_e         state_q;
  rec_t              rec_q;
  logic [WI_W-1:0]   wi_q;
  logic [ADDR_W-1:0] slot_q;
  logic              last_word;

  assign last_word = (wi_q == WI_W'(REC_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      rec_q   <= '0;
      wi_q    <= '0;
      slot_q  <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (start_i) begin
          rec_q   <= words_i;
          wi_q    <= '0;
          slot_q  <= base_i + ADDR_W'({tail_i, 6'b0});
          state_q <= WR_BUSY;
        end
        WR_BUSY: if (mem_ready_i) begin
          if (last_word) state_q <= WR_IDLE;
          else           wi_q    <= wi_q + WI_W'(1);
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  assign idle_o      = (state_q == WR_IDLE);
  assign mem_valid_o = (state_q == WR_BUSY);
  assign done_o      = mem_valid_o && mem_ready_i && last_word;
  assign mem_addr_o  = slot_q + ADDR_W'({wi_q, 3'b000});
  assign mem_data_o  = rec_q[wi_q];
endmodule

// File: rtl/msi_eq_writer.sv
module msi_eq_writer
  import msi_eq_pkg::*;
#(
  parameter int  DEPTH  = 16,
  parameter int  ADDR_W = 48,
  parameter int  TS_W   = 64,
  parameter bit  TS_EN  = 1'b1,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  output logic              ev_ready_o,
  input  logic [2:0]        ev_kind_i,
  input  logic [15:0]       ev_rid_i,
  input  logic [63:0]       ev_addr_i,
  input  logic [31:0]       ev_data_i,
  input  logic [7:0]        ev_msg_tgt_i,
  input  logic [2:0]        ev_msg_route_i,
  input  logic [7:0]        ev_msg_code_i,
  input  logic [1:0]        ev_intx_i,
  input  logic              cfg_enable_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [63:0]       cfg_sysino_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic              err_clr_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_data_o,
  output logic [IDX_W-1:0]  tail_o,
  output logic              irq_o,
  output logic              q_error_o
);
  logic [TS_W-1:0] ts_q;
  rec_t            rec_words;
  logic            legal, full, idle, done;
  logic            take, start, ovf;

  // free-running stamp, starts at 1 so a stamped record is never zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= TS_W'(1);
    else         ts_q <= ts_q + TS_W'(1);
  end

  msi_eq_fmt #(.TS_W(TS_W), .TS_EN(TS_EN)) u_fmt (
    .kind_i   (ev_kind_i),
    .rid_i    (ev_rid_i),
    .addr_i   (ev_addr_i),
    .data_i   (ev_data_i),
    .tgt_i    (ev_msg_tgt_i),
    .route_i  (ev_msg_route_i),
    .code_i   (ev_msg_code_i),
    .intx_i   (ev_intx_i),
    .sysino_i (cfg_sysino_i),
    .ts_i     (ts_q),
    .legal_o  (legal),
    .words_o  (rec_words)
  );

  assign take  = ev_valid_i && idle && cfg_enable_i && !q_error_o && legal;
  assign start = take && !full;
  assign ovf   = take && full;

  msi_eq_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (cfg_enable_i),
    .head_i     (head_i),
    .advance_i  (done),
    .overflow_i (ovf),
    .err_clr_i  (err_clr_i),
    .tail_o     (tail_o),
    .full_o     (full),
    .error_o    (q_error_o),
    .irq_o      (irq_o)
  );

  msi_eq_wr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .words_i     (rec_words),
    .base_i      (cfg_base_i),
    .tail_i      (tail_o),
    .idle_o      (idle),
    .done_o      (done),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o)
  );

  assign ev_ready_o = idle;
endmodule

// File: rtl/msi_eq_chk.sv
module msi_eq_chk #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_ready_o,
  input logic              cfg_enable_i,
  input logic [IDX_W-1:0]  head_i,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [63:0]       mem_data_o,
  input logic [IDX_W-1:0]  tail_o,
  input logic              irq_o,
  input logic              q_error_o
);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_addr_o[2:0] == 3'b000);

  a_r2_tail_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_o != $past(tail_o) |-> tail_o == $past(tail_o) + IDX_W'(1));

  a_r10_irq_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_o == head_i |-> !irq_o);

  a_r10_irq_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_enable_i |-> !irq_o);

  a_r9_err_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_error_o) |-> !mem_valid_o);

  a_r11_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !ev_ready_o);
endmodule

bind msi_eq_writer msi_eq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ev_ready_o   (ev_ready_o),
  .cfg_enable_i (cfg_enable_i),
  .head_i       (head_i),
  .mem_valid_o  (mem_valid_o),
  .mem_ready_i  (mem_ready_i),
  .mem_addr_o   (mem_addr_o),
  .mem_data_o   (mem_data_o),
  .tail_o       (tail_o),
  .irq_o        (irq_o),
  .q_error_o    (q_error_o)
);

// File: tb/sim_msi_eq_writer.sv
module sim_msi_eq_writer;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 4;
  localparam logic [ADDR_W-1:0] BASE = 48'h0000_0001_0000;
  localparam logic [63:0] SYSINO = 64'hCAFE_0000_0000_0042;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic              ev_valid_i = 1'b0;
  logic              ev_ready_o;
  logic [2:0]        ev_kind_i = '0;
  logic [15:0]       ev_rid_i = '0;
  logic [63:0]       ev_addr_i = '0;
  logic [31:0]       ev_data_i = '0;
  logic [7:0]        ev_msg_tgt_i = '0;
  logic [2:0]        ev_msg_route_i = '0;
  logic [7:0]        ev_msg_code_i = '0;
  logic [1:0]        ev_intx_i = '0;
  logic              cfg_enable_i = 1'b1;
  logic [IDX_W-1:0]  head_i = '0;
  logic              err_clr_i = 1'b0;
  logic              mem_valid_o;
  logic              mem_ready_i = 1'b0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [63:0]       mem_data_o;
  logic [IDX_W-1:0]  tail_o;
  logic              irq_o;
  logic              q_error_o;

  msi_eq_writer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ev_valid_i(ev_valid_i), .ev_ready_o(ev_ready_o), .ev_kind_i(ev_kind_i),
    .ev_rid_i(ev_rid_i), .ev_addr_i(ev_addr_i), .ev_data_i(ev_data_i),
    .ev_msg_tgt_i(ev_msg_tgt_i), .ev_msg_route_i(ev_msg_route_i),
    .ev_msg_code_i(ev_msg_code_i), .ev_intx_i(ev_intx_i),
    .cfg_enable_i(cfg_enable_i), .cfg_base_i(BASE), .cfg_sysino_i(SYSINO),
    .head_i(head_i), .err_clr_i(err_clr_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .tail_o(tail_o), .irq_o(irq_o), .q_error_o(q_error_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int wr_cnt  = 0;
  int addr_bad = 0;
  logic [63:0] mem_w [0:DEPTH*8-1];
  logic [IDX_W-1:0] exp_tail = '0;
  logic [63:0] last_ts = '0;

  // memory model: ready chosen at negedge, handshake recorded before the next posedge
  always @(negedge clk) begin
    mem_ready_i = ($urandom % 10) < 7;
    if (rst_ni && mem_valid_o && mem_ready_i) begin
      logic [ADDR_W-1:0] off;
      off = mem_addr_o - BASE;
      if (off >= ADDR_W'(DEPTH * 64) || off[2:0] != 3'b0) addr_bad++;
      mem_w[off[9:3]] = mem_data_o;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word(input int k, input logic [2:0] kind, input logic [15:0] rid,
      input logic [63:0] addr, input logic [31:0] data, input logic [7:0] tgt,
      input logic [2:0] route, input logic [7:0] code, input logic [1:0] intx);
    logic [63:0] w;
    w = '0;
    case (k)
      0: case (kind)
           3'd0: w = 64'd2;
           3'd1: w = 64'd3;
           3'd2: w = (addr[63:32] != 0) ? 64'd3 : 64'd2;
           3'd3: w = 64'd1;
           default: w = 64'd8;
         endcase
      1: w = (kind == 3'd4) ? SYSINO : 64'd0;
      4: w = (kind == 3'd4) ? 64'd0 : {48'd0, rid};
      5: case (kind)
           3'd0: w = {32'd0, addr[31:0]};
           3'd1, 3'd2: w = addr;
           default: w = 64'd0;
         endcase
      6: case (kind)
           3'd0, 3'd1: w = {48'd0, data[15:0]};
           3'd2: w = {32'd0, data};
           3'd3: begin w[39:32] = tgt; w[18:16] = route; w[7:0] = code; end
           default: w[1:0] = intx;
         endcase
      default: w = 64'd0;
    endcase
    return w;
  endfunction

  function automatic string word_tag(input int k);
    case (k)
      0: return "R3 word0";
      4, 5: return "R5 word4/5";
      6: return "R6 word6";
      default: return "R4 word1/2/7";
    endcase
  endfunction

  task automatic send(input logic [2:0] kind, input bit expect_wr, input string tag);
    int pre_cnt;
    logic [IDX_W-1:0] slot;
    while (!ev_ready_o) @(negedge clk);
    pre_cnt = wr_cnt;
    slot = exp_tail;
    ev_kind_i = kind;
    ev_valid_i = 1'b1;
    @(negedge clk);
    ev_valid_i = 1'b0;
    if (expect_wr) begin
      chk(ev_ready_o == 1'b0, "R11 busy", 64'(ev_ready_o), 64'd0);
      while (!ev_ready_o) @(negedge clk);
      exp_tail = exp_tail + IDX_W'(1);
      chk(tail_o == exp_tail, "R2 tail advance", 64'(tail_o), 64'(exp_tail));
      chk(wr_cnt == pre_cnt + 8, "R2 eight writes", 64'(wr_cnt - pre_cnt), 64'd8);
      for (int k = 0; k < 8; k++) begin
        logic [63:0] got;
        got = mem_w[{slot, 3'(k)}];
        if (k == 3) begin
          chk(got != 0 && got > last_ts, "R4 timestamp", got, last_ts + 1);
          last_ts = got;
        end else begin
          logic [63:0] e;
          e = exp_word(k, kind, ev_rid_i, ev_addr_i, ev_data_i, ev_msg_tgt_i,
                       ev_msg_route_i, ev_msg_code_i, ev_intx_i);
          chk(got === e, word_tag(k), got, e);
        end
      end
    end else begin
      @(negedge clk);
      chk(wr_cnt == pre_cnt, {tag, " no write"}, 64'(wr_cnt - pre_cnt), 64'd0);
      chk(tail_o == exp_tail, {tag, " tail held"}, 64'(tail_o), 64'(exp_tail));
    end
  endtask

  task automatic rand_fields();
    ev_rid_i = 16'($urandom);
    ev_addr_i = {32'($urandom), 32'($urandom)};
    ev_data_i = 32'($urandom);
    ev_msg_tgt_i = 8'($urandom);
    ev_msg_route_i = 3'($urandom);
    ev_msg_code_i = 8'($urandom);
    ev_intx_i = 2'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_valid_o == 0, "R1 mem_valid", 64'(mem_valid_o), 0);
    chk(tail_o == 0, "R1 tail", 64'(tail_o), 0);
    chk(irq_o == 0 && q_error_o == 0, "R1 irq/error", {irq_o, q_error_o}, 0);
    chk(ev_ready_o == 1, "R1 ready", 64'(ev_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed kinds
    rand_fields(); send(3'd0, 1'b1, "R3 msi32");
    rand_fields(); send(3'd1, 1'b1, "R3 msi64");
    rand_fields(); ev_addr_i[63:32] = '0; send(3'd2, 1'b1, "R3 msix low");
    rand_fields(); ev_addr_i[63:32] = 32'h1; send(3'd2, 1'b1, "R3 msix high");
    rand_fields(); send(3'd3, 1'b1, "R6 msg");
    rand_fields(); ev_intx_i = 2'd3; send(3'd4, 1'b1, "R6 intx");
    chk(irq_o == 1, "R10 irq pending", 64'(irq_o), 1);

    // R7 reserved kinds and disabled queue
    for (int r = 5; r < 8; r++) begin rand_fields(); send(3'(r), 1'b0, "R7 reserved"); end
    cfg_enable_i = 1'b0;
    @(negedge clk);
    chk(irq_o == 0, "R10 irq disabled", 64'(irq_o), 0);
    rand_fields(); send(3'd1, 1'b0, "R7 disabled");
    cfg_enable_i = 1'b1;

    // random traffic with head consumption
    for (int i = 0; i < 50; i++) begin
      if (($urandom % 3) == 0 || (exp_tail + IDX_W'(1)) == head_i) begin
        head_i = exp_tail;
        @(negedge clk);
        chk(irq_o == 0, "R10 irq drained", 64'(irq_o), 0);
      end
      rand_fields();
      send(3'($urandom % 5), 1'b1, "random");
      chk(irq_o == 1, "R10 irq set", 64'(irq_o), 1);
    end

    // R9 overflow
    head_i = exp_tail;
    for (int i = 0; i < DEPTH - 1; i++) begin rand_fields(); send(3'($urandom % 5), 1'b1, "fill"); end
    chk(q_error_o == 0, "R9 no error before full", 64'(q_error_o), 0);
    rand_fields(); send(3'd0, 1'b0, "R9 overflow");
    chk(q_error_o == 1, "R9 error set", 64'(q_error_o), 1);
    head_i = head_i + IDX_W'(4);
    rand_fields(); send(3'd3, 1'b0, "R9 error drop");
    head_i = exp_tail;
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
    chk(q_error_o == 0, "R9 error cleared", 64'(q_error_o), 0);
    chk(irq_o == 0, "R10 irq empty", 64'(irq_o), 0);
    rand_fields(); send(3'd4, 1'b1, "R9 resume");
    chk(addr_bad == 0, "R2 address range", 64'(addr_bad), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule